// File: doc/BRIEF.md
# Multi-Area Cipher Key Store

This block keeps a bank of 128-bit key areas for a block-cipher engine. Software configures it over a small 32-bit register bus. Key material reaches it as a stream of 32-bit words from an input DMA channel. The words land in the areas that software has enabled, lowest index first. When every enabled area has been filled, those areas are marked valid and a result flag is set.

A second path copies a stored key to the cipher core over a 256-bit parallel bus, one area per cycle. It then pulses a key-valid strobe. Keys of 192 and 256 bits use an even/odd pair of areas. A global key-size field chooses the width, and any write to that field discards every stored key. Sticky flags report bad streams and bad read requests.

The block has two independent state machines, so a stream and a key fetch can run at the same time. The fill machine (`ks_fill_ctrl`) has the states `F_IDLE` and `F_FILL`:
- `F_IDLE` goes to `F_FILL` on the first word accepted against a legal enable mask.
- `F_FILL` goes back to `F_IDLE` when the last word of the last enabled area arrives, or when the stream ends early.

The fetch machine (`ks_fetch_ctrl`) has the states `R_IDLE` and `R_FETCH`:
- `R_IDLE` goes to `R_FETCH` on an accepted read request.
- `R_FETCH` goes back to `R_IDLE` after the last area of the key has been copied.

While `F_FILL` is active, writes to the enable mask are ignored.

Register map (word addresses):

| Address | Register | Contents |
|---|---|---|
| 0 | key size | bits [1:0]: 0 = 128, 1 = 192, 2 = 256 |
| 1 | enable mask | one bit per area |
| 2 | valid map | one bit per area; write 1 to clear |
| 3 | read select | write bits [2:0] = area index; bit 31 reads back as busy |
| 4 | status | bit0 result, bit1 write error, bit2 read error; write 1 to clear |

Top module: `keystore_top`

## Requirements
- R1: After reset, every register reads 0, the busy bit is 0 and `core_key_valid` is low.
- R2: Any write to the key-size register clears the whole valid map, and the new size reads back and appears on `core_key_size`.
- R3: Stream words fill the enabled areas in ascending index order, four words per area, with the first word of an area at bits [31:0]. The word that completes the last enabled area has three effects at the same clock edge: it sets exactly those areas' valid bits, sets status bit0, and clears the enable mask to 0.
- R4: The first accepted word of a stream clears the valid bits of every enabled area.
- R5: A word that arrives while the enable mask is 0 sets status bit1. Nothing is stored and the valid map does not change.
- R6: Status bit1 is set, no valid bit is set and the enable mask is cleared in two cases:
  - the key size is 192 or 256 and the mask does not consist of whole even/odd pairs;
  - `kin_last` arrives before every enabled area is full.
- R7: Writing 1 to a bit of the valid map clears that bit; bits written 0 are unchanged.
- R8: A read request for a valid area in 128-bit mode has the following timing:
  - the busy bit reads 1 on the cycle after the request;
  - the area appears on `core_key[127:0]` with the upper half zero;
  - `core_key_valid` is high for exactly one cycle, at the moment busy falls.
- R9: In 192- or 256-bit mode, a request for even index i delivers area i on bits [127:0] and area i+1 on bits [255:128]. A 192-bit key is returned exactly as delivered, with its zero padding.
- R10: A read request sets status bit2, starts no transfer and produces no strobe in any of these cases:
  - the area is not valid;
  - in wide mode, the index is odd;
  - in wide mode, the partner area is not valid.
- R11: Writing 1 to a status bit clears it. An event that occurs in the same cycle as the clear leaves its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| kin_valid | input | 1 | Key stream word valid |
| kin_data | input | 32 | Key stream word |
| kin_last | input | 1 | Marks the final word of a stream |
| core_key | output | 256 | Key delivered to the cipher core |
| core_key_valid | output | 1 | One-cycle strobe when a key transfer completes |
| core_key_size | output | 2 | Current key-size setting |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the final word of a fill and a read request. The bench drives both on the same edge, against an area that the fill has just invalidated. The request must still see the old valid map, so the result flag and the read-error flag must both appear, and the area must become valid only afterwards.

The second pair is a status write-one-to-clear and a new write error. The bench drives an unexpected key word together with the clear of all status bits. The new error must survive while the older flags are removed.

// File: rtl/ks_pkg.sv
package ks_pkg;

    typedef enum logic [1:0] {
        KSZ_128  = 2'd0,
        KSZ_192  = 2'd1,
        KSZ_256  = 2'd2,
        KSZ_RSVD = 2'd3
    } ks_size_e;

    localparam int KS_ADDR_W = 3;

    localparam logic [KS_ADDR_W-1:0] RA_SIZE  = 3'd0;
    localparam logic [KS_ADDR_W-1:0] RA_WREN  = 3'd1;
    localparam logic [KS_ADDR_W-1:0] RA_VALID = 3'd2;
    localparam logic [KS_ADDR_W-1:0] RA_RDSEL = 3'd3;
    localparam logic [KS_ADDR_W-1:0] RA_STAT  = 3'd4;

    localparam int ST_RESULT = 0;
    localparam int ST_WERR   = 1;
    localparam int ST_RERR   = 2;
    localparam int ST_W      = 3;

endpackage

// File: rtl/ks_area_store.sv
module ks_area_store #(
    parameter int NUM_AREAS      = 8,
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_AREA = 4,
    localparam int AREA_W        = WORD_W * WORDS_PER_AREA,
    localparam int IDX_W         = $clog2(NUM_AREAS),
    localparam int WSEL_W        = $clog2(WORDS_PER_AREA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_area,
    input  logic [WSEL_W-1:0] w_word,
    input  logic [WORD_W-1:0] w_data,
    input  logic [IDX_W-1:0]  r_area,
    output logic [AREA_W-1:0] r_data
);

    logic [WORD_W-1:0] mem [NUM_AREAS][WORDS_PER_AREA];

    for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
        for (genvar w = 0; w < WORDS_PER_AREA; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[a][w] <= '0;
                end else if (we && w_area == IDX_W'(a) && w_word == WSEL_W'(w)) begin
                    mem[a][w] <= w_data;
                end
            end
        end
    end

    always_comb begin
        for (int w = 0; w < WORDS_PER_AREA; w++) begin
            r_data[w*WORD_W +: WORD_W] = mem[r_area][w];
        end
    end

endmodule

// File: rtl/ks_fill_ctrl.sv
module ks_fill_ctrl #(
    parameter int NUM_AREAS      = 8,
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_AREA = 4,
    localparam int IDX_W         = $clog2(NUM_AREAS),
    localparam int WSEL_W        = $clog2(WORDS_PER_AREA)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    input  logic [WORD_W-1:0]    s_data,
    input  logic                 s_last,
    input  logic [NUM_AREAS-1:0] en_mask,
    input  logic                 wide,
    output logic                 st_we,
    output logic [IDX_W-1:0]     st_area,
    output logic [WSEL_W-1:0]    st_word,
    output logic [WORD_W-1:0]    st_data,
    output logic [NUM_AREAS-1:0] start_clr,
    output logic                 done,
    output logic [NUM_AREAS-1:0] done_mask,
    output logic                 fail,
    output logic                 consume,
    output logic                 active
);

    typedef enum logic {F_IDLE, F_FILL} fill_state_e;

    fill_state_e          state, state_n;
    logic [NUM_AREAS-1:0] rem, rem_n, orig, orig_n;
    logic [WSEL_W-1:0]    wcnt, wcnt_n;
    logic                 pair_ok;
    logic [IDX_W-1:0]     cur_idx;
    logic [NUM_AREAS-1:0] rem_left;

    function automatic logic [IDX_W-1:0] lowest(input logic [NUM_AREAS-1:0] m);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NUM_AREAS - 1; i >= 0; i--) begin
            if (m[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    always_comb begin
        pair_ok = 1'b1;
        for (int i = 0; i < NUM_AREAS / 2; i++) begin
            if (en_mask[2*i] != en_mask[2*i+1]) pair_ok = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= F_IDLE;
            rem   <= '0;
            orig  <= '0;
            wcnt  <= '0;
        end else begin
            state <= state_n;
            rem   <= rem_n;
            orig  <= orig_n;
            wcnt  <= wcnt_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n   = state;
        rem_n     = rem;
        orig_n    = orig;
        wcnt_n    = wcnt;
        st_we     = 1'b0;
        st_word   = wcnt;
        st_data   = s_data;
        start_clr = '0;
        done      = 1'b0;
        fail      = 1'b0;
        consume   = 1'b0;
        cur_idx   = lowest(rem);
        rem_left  = rem & ~(NUM_AREAS'(1) << cur_idx);
        unique case (state)
            F_IDLE: begin
                cur_idx = lowest(en_mask);
                if (s_valid) begin
                    if (en_mask == '0 || (wide && !pair_ok)) begin
                        fail    = 1'b1;
                        consume = 1'b1;
                    end else begin
                        st_we     = 1'b1;
                        st_word   = '0;
                        start_clr = en_mask;
                        orig_n    = en_mask;
                        rem_n     = en_mask;
                        wcnt_n    = WSEL_W'(1);
                        if (s_last) begin
                            fail    = 1'b1;
                            consume = 1'b1;
                        end else begin
                            state_n = F_FILL;
                        end
                    end
                end
            end
            F_FILL: begin
                if (s_valid) begin
                    st_we = 1'b1;
                    if (wcnt == WSEL_W'(WORDS_PER_AREA - 1)) begin
                        wcnt_n = '0;
                        rem_n  = rem_left;
                        if (rem_left == '0) begin
                            done    = 1'b1;
                            consume = 1'b1;
                            state_n = F_IDLE;
                        end else if (s_last) begin
                            fail    = 1'b1;
                            consume = 1'b1;
                            state_n = F_IDLE;
                        end
                    end else begin
                        wcnt_n = wcnt + 1'b1;
                        if (s_last) begin
                            fail    = 1'b1;
                            consume = 1'b1;
                            state_n = F_IDLE;
                        end
                    end
                end
            end
        endcase
        st_area = cur_idx;
    end

    assign done_mask = orig;
    assign active    = (state == F_FILL);

    // R3: every stored word goes to an area the enable mask allows
    a_r3_write_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> en_mask[st_area]);

    // R6: a stream never both completes and fails
    a_r6_done_not_fail: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

endmodule

// File: rtl/ks_fetch_ctrl.sv
module ks_fetch_ctrl #(
    parameter int NUM_AREAS = 8,
    parameter int AREA_W    = 128,
    localparam int IDX_W    = $clog2(NUM_AREAS),
    localparam int KEY_W    = 2 * AREA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [IDX_W-1:0]     req_idx,
    input  logic                 wide,
    input  logic [NUM_AREAS-1:0] valid_map,
    input  logic [AREA_W-1:0]    area_data,
    output logic [IDX_W-1:0]     rd_area,
    output logic                 busy,
    output logic [KEY_W-1:0]     key,
    output logic                 key_valid,
    output logic                 rd_err
);

    typedef enum logic {R_IDLE, R_FETCH} fetch_state_e;

    fetch_state_e     state, state_n;
    logic [IDX_W-1:0] base_idx;
    logic             half, wide_r;
    logic             accept, req_ok, last_half;
    logic [KEY_W-1:0] key_r;
    logic             kv_r;

    always_comb begin
        req_ok = valid_map[req_idx];
        if (wide) begin
            req_ok = req_ok && !req_idx[0] && valid_map[req_idx | IDX_W'(1)];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= state_n;
    end

    // next state and outputs
    always_comb begin
        state_n = state;
        accept  = 1'b0;
        rd_err  = 1'b0;
        unique case (state)
            R_IDLE: begin
                if (req) begin
                    if (req_ok) begin
                        accept  = 1'b1;
                        state_n = R_FETCH;
                    end else begin
                        rd_err = 1'b1;
                    end
                end
            end
            R_FETCH: begin
                if (last_half) state_n = R_IDLE;
            end
        endcase
    end

    assign last_half = !wide_r || half;
    assign rd_area   = {base_idx[IDX_W-1:1], base_idx[0] | half};
    assign busy      = (state == R_FETCH);
    assign key       = key_r;
    assign key_valid = kv_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_idx <= '0;
            half     <= 1'b0;
            wide_r   <= 1'b0;
            key_r    <= '0;
            kv_r     <= 1'b0;
        end else begin
            kv_r <= (state == R_FETCH) && last_half;
            if (accept) begin
                base_idx <= req_idx;
                half     <= 1'b0;
                wide_r   <= wide;
                key_r    <= '0;
            end else if (state == R_FETCH) begin
                half <= 1'b1;
                if (half) key_r[KEY_W-1:AREA_W] <= area_data;
                else      key_r[AREA_W-1:0]     <= area_data;
            end
        end
    end

    // R8: the strobe lasts one cycle
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    // R8: busy falls exactly when the strobe appears
    a_r8_busy_ends_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> key_valid);

    // R10: a rejected request starts no transfer
    a_r10_err_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> !busy);

endmodule

// File: rtl/keystore_top.sv
module keystore_top
    import ks_pkg::*;
#(
    parameter int NUM_AREAS      = 8,
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_AREA = 4,
    parameter int REG_W          = 32,
    localparam int AREA_W        = WORD_W * WORDS_PER_AREA,
    localparam int KEY_W         = 2 * AREA_W,
    localparam int IDX_W         = $clog2(NUM_AREAS),
    localparam int WSEL_W        = $clog2(WORDS_PER_AREA)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [KS_ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 kin_valid,
    input  logic [WORD_W-1:0]    kin_data,
    input  logic                 kin_last,
    output logic [KEY_W-1:0]     core_key,
    output logic                 core_key_valid,
    output logic [1:0]           core_key_size
);

    ks_size_e             size_q;
    logic [NUM_AREAS-1:0] wren_q, valid_q;
    logic [ST_W-1:0]      stat_q, stat_set;
    logic [IDX_W-1:0]     rdsel_q;
    logic                 wide;

    logic                 wr_size, wr_wren, wr_valid, wr_rdsel, wr_stat;

    logic                 st_we;
    logic [IDX_W-1:0]     st_area, rd_area;
    logic [WSEL_W-1:0]    st_word;
    logic [WORD_W-1:0]    st_data;
    logic [NUM_AREAS-1:0] start_clr, done_mask;
    logic                 fill_done, fill_fail, fill_consume, fill_active;
    logic [AREA_W-1:0]    area_data;
    logic                 fetch_busy, rd_err;

    assign wide     = (size_q != KSZ_128);
    assign wr_size  = reg_we && (reg_addr == RA_SIZE);
    assign wr_wren  = reg_we && (reg_addr == RA_WREN);
    assign wr_valid = reg_we && (reg_addr == RA_VALID);
    assign wr_rdsel = reg_we && (reg_addr == RA_RDSEL);
    assign wr_stat  = reg_we && (reg_addr == RA_STAT);

    ks_area_store #(
        .NUM_AREAS(NUM_AREAS), .WORD_W(WORD_W), .WORDS_PER_AREA(WORDS_PER_AREA)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(st_we), .w_area(st_area), .w_word(st_word), .w_data(st_data),
        .r_area(rd_area), .r_data(area_data)
    );

    ks_fill_ctrl #(
        .NUM_AREAS(NUM_AREAS), .WORD_W(WORD_W), .WORDS_PER_AREA(WORDS_PER_AREA)
    ) u_fill (
        .clk(clk), .rst_n(rst_n),
        .s_valid(kin_valid), .s_data(kin_data), .s_last(kin_last),
        .en_mask(wren_q), .wide(wide),
        .st_we(st_we), .st_area(st_area), .st_word(st_word), .st_data(st_data),
        .start_clr(start_clr), .done(fill_done), .done_mask(done_mask),
        .fail(fill_fail), .consume(fill_consume), .active(fill_active)
    );

    ks_fetch_ctrl #(
        .NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .req(wr_rdsel), .req_idx(reg_wdata[IDX_W-1:0]), .wide(wide),
        .valid_map(valid_q), .area_data(area_data), .rd_area(rd_area),
        .busy(fetch_busy), .key(core_key), .key_valid(core_key_valid),
        .rd_err(rd_err)
    );

    always_comb begin
        stat_set            = '0;
        stat_set[ST_RESULT] = fill_done;
        stat_set[ST_WERR]   = fill_fail;
        stat_set[ST_RERR]   = rd_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q  <= KSZ_128;
            wren_q  <= '0;
            valid_q <= '0;
            stat_q  <= '0;
            rdsel_q <= '0;
        end else begin
            if (wr_size) size_q <= ks_size_e'(reg_wdata[1:0]);

            if (fill_consume)                wren_q <= '0;
            else if (wr_wren && !fill_active) wren_q <= reg_wdata[NUM_AREAS-1:0];

            if (wr_size) begin
                valid_q <= '0;
            end else begin
                valid_q <= (valid_q & ~(wr_valid ? reg_wdata[NUM_AREAS-1:0] : '0) & ~start_clr)
                         | (fill_done ? done_mask : '0);
            end

            stat_q <= (stat_q & ~(wr_stat ? reg_wdata[ST_W-1:0] : '0)) | stat_set;

            if (wr_rdsel && !fetch_busy) rdsel_q <= reg_wdata[IDX_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_SIZE:  reg_rdata = REG_W'(size_q);
            RA_WREN:  reg_rdata = REG_W'(wren_q);
            RA_VALID: reg_rdata = REG_W'(valid_q);
            RA_RDSEL: reg_rdata = {fetch_busy, {(REG_W-1-IDX_W){1'b0}}, rdsel_q};
            RA_STAT:  reg_rdata = REG_W'(stat_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign core_key_size = size_q;

    // R2: a size write leaves no key valid
    a_r2_size_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_size |=> (valid_q == '0));

    // R3: the result flag only rises after a fill completes
    a_r3_result_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_RESULT]) |-> $past(fill_done));

    // R10: the read-error flag only rises after a read request
    a_r10_rderr_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_RERR]) |-> $past(wr_rdsel));

    // R6: a consumed stream leaves the enable mask empty
    a_r6_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        fill_consume |=> (wren_q == '0));

endmodule

// File: tb/tb_keystore_top.sv
module tb_keystore_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         kin_valid = 1'b0;
    logic [31:0]  kin_data = '0;
    logic         kin_last = 1'b0;
    logic [255:0] core_key;
    logic         core_key_valid;
    logic [1:0]   core_key_size;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [255:0] exp_q[$];

    keystore_top dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .kin_valid(kin_valid), .kin_data(kin_data), .kin_last(kin_last),
        .core_key(core_key), .core_key_valid(core_key_valid), .core_key_size(core_key_size)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] kw(input int tag, input int j);
        return 32'h5A00_0000 | (tag << 8) | j;
    endfunction

    function automatic logic [127:0] akey(input int tag);
        return {kw(tag, 3), kw(tag, 2), kw(tag, 1), kw(tag, 0)};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic word(input logic [31:0] d, input logic last);
        kin_valid = 1'b1; kin_data = d; kin_last = last;
        @(negedge clk);
        kin_valid = 1'b0; kin_last = 1'b0;
    endtask

    task automatic area_words(input int tag, input logic last_on_end);
        for (int j = 0; j < 4; j++) word(kw(tag, j), last_on_end && j == 3);
    endtask

    // driver: pushes the expected key, issues the request, waits for completion
    task automatic fetch(input int idx, input logic [255:0] exp);
        logic [31:0] d;
        exp_q.push_back(exp);
        wr(3'd3, idx);
        rd(3'd3, d);
        chk("R8 busy after request", d[31], 1'b1);
        repeat (4) @(negedge clk);
        rd(3'd3, d);
        chk("R8 busy cleared", d[31], 1'b0);
    endtask

    task automatic bad_fetch(input int idx, input string req);
        logic [31:0] d;
        wr(3'd4, 32'h7);
        wr(3'd3, idx);
        rd(3'd3, d);
        chk({req, " no transfer"}, d[31], 1'b0);
        rd(3'd4, d);
        chk({req, " read error flag"}, d[2:0], 3'b100);
        repeat (3) @(negedge clk);
    endtask

    // monitor: compare each delivered key with the scoreboard
    always @(negedge clk) begin
        if (rst_n && core_key_valid) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected key strobe", 256'd1, 256'd0);
            end else begin
                chk("R8/R9 delivered key", core_key, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 register reset", d, 0);
        end
        chk("R1 strobe low", core_key_valid, 0);

        // R3 fill areas 1 and 2 in 128-bit mode
        wr(3'd0, 0);
        wr(3'd1, 32'h06);
        area_words(1, 0);
        area_words(2, 1);
        rd(3'd2, d); chk("R3 valid map after fill", d, 32'h06);
        rd(3'd4, d); chk("R3 result flag", d, 32'h1);
        rd(3'd1, d); chk("R3 enable mask consumed", d, 0);
        fetch(1, {128'd0, akey(1)});
        fetch(2, {128'd0, akey(2)});

        // R11 status clear
        wr(3'd4, 32'h7);
        rd(3'd4, d); chk("R11 status cleared", d, 0);

        // R4/R6 early end: areas 1 and 3 enabled, stream ends after 3 words
        wr(3'd1, 32'h0A);
        word(kw(9, 0), 0); word(kw(9, 1), 0); word(kw(9, 2), 1);
        rd(3'd2, d); chk("R4 enabled area invalidated", d, 32'h04);
        rd(3'd4, d); chk("R6 short stream error", d, 32'h2);
        rd(3'd1, d); chk("R6 mask cleared on error", d, 0);

        // R10 invalid area, then R8 valid area untouched
        bad_fetch(1, "R10 invalid area");
        fetch(2, {128'd0, akey(2)});

        // R5 word with empty mask
        wr(3'd4, 32'h7);
        word(32'hDEAD_BEEF, 0);
        rd(3'd4, d); chk("R5 stray word error", d, 32'h2);
        rd(3'd2, d); chk("R5 valid map unchanged", d, 32'h04);

        // R2 size write wipes keys
        wr(3'd0, 2);
        rd(3'd2, d); chk("R2 valid cleared", d, 0);
        rd(3'd0, d); chk("R2 size readback", d, 2);
        chk("R2 size output", core_key_size, 2);

        // R6 unpaired mask in 256-bit mode
        wr(3'd4, 32'h7);
        wr(3'd1, 32'h06);
        word(kw(7, 0), 0);
        rd(3'd4, d); chk("R6 unpaired mask error", d, 32'h2);
        rd(3'd1, d); chk("R6 unpaired mask cleared", d, 0);
        rd(3'd2, d); chk("R6 nothing valid", d, 0);

        // R9 256-bit key in areas 4 and 5
        wr(3'd4, 32'h7);
        wr(3'd1, 32'h30);
        area_words(4, 0);
        area_words(5, 1);
        rd(3'd2, d); chk("R3 wide valid map", d, 32'h30);
        fetch(4, {akey(5), akey(4)});
        bad_fetch(5, "R10 odd index");

        // R9 192-bit key with zero padding
        wr(3'd0, 1);
        wr(3'd1, 32'h03);
        area_words(0, 0);
        word(kw(1, 0), 0); word(kw(1, 1), 0); word(32'd0, 0); word(32'd0, 1);
        fetch(0, {64'd0, kw(1, 1), kw(1, 0), akey(0)});

        // R7 clear partner bit, then R10 partner invalid
        wr(3'd2, 32'h02);
        rd(3'd2, d); chk("R7 write-one-to-clear valid", d, 32'h01);
        bad_fetch(0, "R10 partner invalid");

        // R11 status clear coinciding with a new write error
        fork
            wr(3'd4, 32'h7);
            word(32'h1234_5678, 0);
        join
        rd(3'd4, d); chk("R11 event beats clear", d, 32'h2);

        // same-cycle fill completion and read request
        wr(3'd0, 0);
        wr(3'd4, 32'h7);
        wr(3'd1, 32'h01);
        for (int j = 0; j < 3; j++) word(kw(3, j), 0);
        fork
            word(kw(3, 3), 1);
            wr(3'd3, 0);
        join
        rd(3'd4, d); chk("R11 result and read error together", d, 32'h5);
        rd(3'd2, d); chk("R3 area valid after completion", d, 32'h01);
        repeat (3) @(negedge clk);
        fetch(0, {128'd0, akey(3)});

        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule